// File: doc/BRIEF.md
# Parallel ATA Host Interrupt Generator and Line Router

This block produces the host-side interrupt of a parallel ATA channel and steers it onto one of two legacy interrupt lines, IRQ14 or IRQ15. An interrupt comes from one of two sources. The first is a rising edge on the drive's interrupt wire, which is asynchronous to the block clock. The second is the completion of a transfer descriptor whose interrupt-on-completion flag is set. Each new interrupt sets a sticky status bit. Software clears that bit by writing a one, and starting a new transfer also clears it. Each new interrupt also produces a single-cycle, active-high pulse on the selected line, which suits an edge-triggered interrupt controller.

The line is chosen from two inputs: a combined-mode enable and a 2-bit port-mapping value. When the channel runs standalone, it always uses IRQ14. In combined mode, a mapping value of 1 makes the channel the logical primary, so it uses IRQ14. A mapping value of 2 makes it the logical secondary, so it uses IRQ15. The other two mapping values keep both lines quiet while the status bit still records the event. The interrupt never goes to a PCI interrupt pin or to a serial interrupt stream.

No data flows through the block, so it has no valid/ready interface. Every pin is a plain control or status signal. Event and clear inputs are one-cycle strobes in the block clock domain.

Top module: `ide_irq_router`

## Requirements
- R1: After reset, `irq_status_o`, `irq14_o` and `irq15_o` are all 0.
- R2: `dev_irq_i` passes through SYNC_STAGES flip-flops (default 2) and only its rising edge counts as an event. With the default depth, the pulse is high after the third rising clock edge that follows the input going high. It is low again after the fourth. Holding the input high gives exactly one event.
- R3: A `desc_done_i` strobe with `desc_ioc_i`=1 sets the status bit and raises the pulse at the next clock edge. A `desc_done_i` strobe with `desc_ioc_i`=0 leaves the status bit unchanged and gives no pulse.
- R4: With `combined_en_i`=0, every interrupt pulse appears on `irq14_o`, whatever the value of `port_map_i`.
- R5: With `combined_en_i`=1 and `port_map_i`=1, the pulse appears on `irq14_o` (the channel is the logical primary).
- R6: With `combined_en_i`=1 and `port_map_i`=2, the pulse appears on `irq15_o` (the channel is the logical secondary).
- R7: With `combined_en_i`=1 and `port_map_i` equal to 0 or 3, both outputs stay low, while the status bit is still set.
- R8: Each pulse lasts exactly one clock cycle. `irq14_o` and `irq15_o` are never high in the same cycle.
- R9: The status bit stays set until `sts_w1c_i` or `xfer_start_i` is strobed, and it reads 0 after that edge. If a new event and a clear arrive in the same cycle, the event wins and the bit stays 1.
- R10: An event that arrives while the status bit is already 1 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq_i | input | 1 | Drive interrupt wire, asynchronous |
| desc_done_i | input | 1 | Strobe: a transfer descriptor has completed |
| desc_ioc_i | input | 1 | Interrupt-on-completion flag of the completed descriptor |
| xfer_start_i | input | 1 | Strobe: a new transfer starts; clears the status bit |
| sts_w1c_i | input | 1 | Strobe: software wrote one to the status bit |
| combined_en_i | input | 1 | 1 = combined mode, 0 = standalone |
| port_map_i | input | 2 | Logical channel mapping used in combined mode |
| irq_status_o | output | 1 | Sticky interrupt status |
| irq14_o | output | 1 | One-cycle interrupt pulse on legacy line 14 |
| irq15_o | output | 1 | One-cycle interrupt pulse on legacy line 15 |

## Verification
A status bit that is stuck or wrongly cleared shows up on `irq_status_o` one edge after the event or clear that should have moved it. It also shows up at the next event, as a missing pulse or an extra one, because a pulse depends on the bit being clear. A wrong route decode shows on the wrong line, or on both lines, in the cycle after the event. A fault in the synchronizer or the edge detector shows as a pulse that comes early or late against the three-edge latency, or as repeated pulses while the drive holds its wire high.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;

  localparam int MAP_W = 2;
  localparam int LINES = 2;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_L14  = 2'd1,
    ROUTE_L15  = 2'd2
  } irq_route_e;

  // Turn the mode inputs into the legacy line to drive.
  function automatic irq_route_e route_decode(input logic combined,
                                              input logic [MAP_W-1:0] map);
    irq_route_e r;
    if (!combined) begin
      r = ROUTE_L14;
    end else begin
      unique case (map)
        2'd1:    r = ROUTE_L14;
        2'd2:    r = ROUTE_L15;
        default: r = ROUTE_NONE;
      endcase
    end
    return r;
  endfunction

  // Index 0 is line 14, index 1 is line 15.
  function automatic irq_route_e route_of_line(input int idx);
    return (idx == 0) ? ROUTE_L14 : ROUTE_L15;
  endfunction

endpackage

// File: rtl/ide_irq_sync_edge.sv
module ide_irq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              synced;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign synced = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;
  end

  assign rise_o = synced & ~prev_q;

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/ide_irq_status.sv
module ide_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic status_o,
  output logic fresh_o
);

  logic status_q;

  // An event takes priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status_q <= 1'b0;
    else if (set_i) status_q <= 1'b1;
    else if (clr_i) status_q <= 1'b0;
  end

  assign status_o = status_q;
  assign fresh_o  = set_i & ~status_q;

  // R9
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> status_o);

  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !status_o);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(status_o));

endmodule

// File: rtl/ide_irq_line_mux.sv
module ide_irq_line_mux
  import ide_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic             combined_i,
  input  logic [MAP_W-1:0] map_i,
  output logic [LINES-1:0] line_o
);

  irq_route_e       route;
  logic [LINES-1:0] line_q;

  assign route = route_decode(combined_i, map_i);

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q[i] <= 1'b0;
        else        line_q[i] <= fire_i && (route == route_of_line(i));
      end

      // R8
      pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_q[i] |=> !line_q[i]);
    end
  endgenerate

  assign line_o = line_q;

  // R8
  lines_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_q[0] && line_q[1]));

  // R6
  l15_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_q[1] |-> $past(combined_i && map_i == 2'd2));

  // R4 R5
  l14_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_q[0] |-> $past(!combined_i || map_i == 2'd1));

  // R7
  quiet_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (combined_i && (map_i == 2'd0 || map_i == 2'd3)) |=> line_q == '0);

endmodule

// File: rtl/ide_irq_router.sv
module ide_irq_router
  import ide_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dev_irq_i,
  input  logic             desc_done_i,
  input  logic             desc_ioc_i,
  input  logic             xfer_start_i,
  input  logic             sts_w1c_i,
  input  logic             combined_en_i,
  input  logic [MAP_W-1:0] port_map_i,
  output logic             irq_status_o,
  output logic             irq14_o,
  output logic             irq15_o
);

  logic             dev_rise;
  logic             irq_event;
  logic             sts_clear;
  logic             fresh;
  logic [LINES-1:0] lines;

  ide_irq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (dev_irq_i),
    .rise_o  (dev_rise)
  );

  assign irq_event = dev_rise | (desc_done_i & desc_ioc_i);
  assign sts_clear = sts_w1c_i | xfer_start_i;

  ide_irq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (irq_event),
    .clr_i    (sts_clear),
    .status_o (irq_status_o),
    .fresh_o  (fresh)
  );

  ide_irq_line_mux u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_i     (fresh),
    .combined_i (combined_en_i),
    .map_i      (port_map_i),
    .line_o     (lines)
  );

  assign irq14_o = lines[0];
  assign irq15_o = lines[1];

  // R10
  no_repeat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq14_o || irq15_o) |-> !$past(irq_status_o));

  // R3
  ioc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_done_i && desc_ioc_i) |=> irq_status_o);

  // R3
  pulse_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq14_o || irq15_o) |-> irq_status_o);

endmodule

// File: tb/tb_ide_irq_router.sv
module tb_ide_irq_router;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dev_irq = 1'b0;
  logic       desc_done = 1'b0;
  logic       desc_ioc = 1'b0;
  logic       xfer_start = 1'b0;
  logic       sts_w1c = 1'b0;
  logic       combined = 1'b0;
  logic [1:0] pmap = 2'd0;
  logic       status, irq14, irq15;

  int total = 0;
  int bad = 0;
  int cnt14 = 0;
  int cnt15 = 0;
  int cnt_both = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ide_irq_router dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .dev_irq_i     (dev_irq),
    .desc_done_i   (desc_done),
    .desc_ioc_i    (desc_ioc),
    .xfer_start_i  (xfer_start),
    .sts_w1c_i     (sts_w1c),
    .combined_en_i (combined),
    .port_map_i    (pmap),
    .irq_status_o  (status),
    .irq14_o       (irq14),
    .irq15_o       (irq15)
  );

  always @(negedge clk) begin
    cnt14 += int'(irq14);
    cnt15 += int'(irq15);
    if (irq14 && irq15) cnt_both++;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_counts();
    cnt14 = 0; cnt15 = 0; cnt_both = 0;
  endtask

  task automatic w1c();
    sts_w1c = 1'b1; step(); sts_w1c = 1'b0;
  endtask

  task automatic desc_strobe(input logic ioc);
    desc_done = 1'b1; desc_ioc = ioc; step();
    desc_done = 1'b0; desc_ioc = 1'b0;
  endtask

  // Fields: combined, map[1:0], src[1:0] (0 drive wire, 1 descriptor with flag,
  // 2 descriptor without flag), expected line14, expected line15.
  localparam logic [6:0] VEC [10] = '{
    {1'b0, 2'd0, 2'd1, 1'b1, 1'b0},
    {1'b0, 2'd2, 2'd0, 1'b1, 1'b0},
    {1'b0, 2'd3, 2'd1, 1'b1, 1'b0},
    {1'b1, 2'd1, 2'd1, 1'b1, 1'b0},
    {1'b1, 2'd1, 2'd0, 1'b1, 1'b0},
    {1'b1, 2'd2, 2'd1, 1'b0, 1'b1},
    {1'b1, 2'd2, 2'd0, 1'b0, 1'b1},
    {1'b1, 2'd0, 2'd1, 1'b0, 1'b0},
    {1'b1, 2'd3, 2'd0, 1'b0, 1'b0},
    {1'b1, 2'd2, 2'd2, 1'b0, 1'b0}
  };

  initial begin
    #(4 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", int'(status), 0);
    check("R1 irq14", int'(irq14), 0);
    check("R1 irq15", int'(irq15), 0);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < 10; i++) begin
      logic [1:0] src;
      string tag;
      combined = VEC[i][6];
      pmap     = VEC[i][5:4];
      src      = VEC[i][3:2];
      if (src == 2)          tag = "R3 no-flag";
      else if (!combined)    tag = "R4 standalone";
      else if (pmap == 2'd1) tag = "R5 primary";
      else if (pmap == 2'd2) tag = "R6 secondary";
      else                   tag = "R7 quiet map";
      w1c();
      step();
      clear_counts();
      if (src == 0) begin
        dev_irq = 1'b1;
        repeat (6) step();
        dev_irq = 1'b0;
      end else begin
        desc_strobe(src == 1);
        repeat (5) step();
      end
      check({tag, " line14 pulses"}, cnt14, int'(VEC[i][1]));
      check({tag, " line15 pulses"}, cnt15, int'(VEC[i][0]));
      check({tag, " status"}, int'(status), (src == 2) ? 0 : 1);
      check("R8 both lines", cnt_both, 0);
      repeat (4) step();
    end

    // R2 latency of the drive wire, standalone mode
    combined = 1'b0; pmap = 2'd0;
    w1c(); step();
    dev_irq = 1'b1;
    step(); check("R2 edge1", int'(irq14), 0);
    step(); check("R2 edge2", int'(irq14), 0);
    step(); check("R2 edge3", int'(irq14), 1);
    step(); check("R8 edge4 pulse ends", int'(irq14), 0);
    repeat (4) step();
    dev_irq = 1'b0;
    repeat (4) step();

    // R3 descriptor latency and R8 width
    w1c(); step();
    desc_done = 1'b1; desc_ioc = 1'b1;
    step();
    desc_done = 1'b0; desc_ioc = 1'b0;
    check("R3 pulse next edge", int'(irq14), 1);
    check("R3 status next edge", int'(status), 1);
    step();
    check("R8 one cycle", int'(irq14), 0);

    // R10 event while status set: no pulse
    clear_counts();
    desc_strobe(1'b1);
    repeat (3) step();
    check("R10 no pulse", cnt14 + cnt15, 0);
    check("R10 status", int'(status), 1);

    // R9 sticky and clears
    repeat (5) step();
    check("R9 sticky", int'(status), 1);
    w1c();
    check("R9 w1c clears", int'(status), 0);
    desc_strobe(1'b1); step();
    xfer_start = 1'b1; step(); xfer_start = 1'b0;
    check("R9 start clears", int'(status), 0);
    desc_strobe(1'b1); step();
    sts_w1c = 1'b1; desc_done = 1'b1; desc_ioc = 1'b1;
    step();
    sts_w1c = 1'b0; desc_done = 1'b0; desc_ioc = 1'b0;
    check("R9 set beats clear", int'(status), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule